// File: doc/BRIEF.md
# Quarter-Wave Phase Accumulator Sine Source

This block is a direct digital synthesis core. A 16-bit tuning word sets the output frequency. Once every fourth input clock the word is added into a 21-bit phase register. The three upper fields of the phase drive a quarter-wave magnitude table, which reaches all four quadrants of the sine through folding:

- one bit gives the sign;
- one bit selects the mirrored quadrant;
- seven bits give the table address.

The result is an 8-bit sign-magnitude sample. It is held in an output register that feeds an external DAC. A one-clock strobe marks each new sample. The output frequency is fclk × D / 2^23, so the frequency step equals fclk / 2^23.

The DAC, the analog smoothing filter and amplitude scaling sit downstream and are not part of the block. The tuning word is sampled on each update cycle. A new word therefore takes effect at the next update without any handshake.

Top module: `sine_dds_core`

## Requirements
- R1: While `rst_n` is low (asynchronously), `sample_code` is 0 and `sample_valid` is 0.
- R2: After reset release, updates occur on the 4th rising edge and on every 4th edge after it. `sample_valid` is high for exactly the one clock that follows each update edge and low otherwise.
- R3: The 21-bit phase starts at 0 and gains the zero-extended `tune_word` on each update, wrapping modulo 2^21. The sample loaded at update n (n from 1) is derived from phase (n-1)·D mod 2^21.
- R4: `sample_code[7]` (the sign) equals bit 20 of the phase used for that sample.
- R5: When phase bit 19 is set, the 7-bit address taken from phase bits 18:12 is bit-inverted before the lookup. Phase bits 11:0 have no effect on the sample.
- R6: `sample_code[6:0]` equals round(127·sin(π/2·(k+0.5)/128)) for lookup index k, so index 0 yields 1 and index 127 yields 127.
- R7: With `tune_word` = 0 the phase is frozen, and every update reloads the same sample.
- R8: `sample_code` changes only on update edges and holds its value between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 16 | Frequency tuning word D |
| sample_code | output | 8 | Registered sign-magnitude sample: bit 7 sign, bits 6:0 magnitude |
| sample_valid | output | 1 | One-clock strobe after each sample update |

## Verification
The bench runs six tuning words, each from a fresh reset:

| Tuning word | What it shows |
|---|---|
| 0x1000 | Steps the table address by one, so every table entry and both quadrant mirror points are visited in order. |
| 0xFFFF | Makes large steps that cross all quadrants within a few dozen updates, with carries running through the whole accumulator. |
| 0x0400 | Steps by a quarter address, so repeated entries must hold. |
| 0x8001 | Leaves an odd remainder in the discarded low bits. |
| 0x0001 | Stays below the discarded-bit range and must hold the first entry. |
| 0 | Must freeze the output. |

In every clock the strobe and the held code are compared with a phase model of the bench's own. An asynchronous reset in the middle of a run confirms that the outputs clear.

// File: rtl/sine_dds_pkg.sv
package sine_dds_pkg;

  localparam longint Q30_ONE = 64'sd1073741824;
  localparam longint PI_Q30  = 64'sd3373259426;

  // Elaboration-time quarter-wave value: round(amp * sin(pi/2 * (k + 0.5) / depth)),
  // evaluated with a fixed-point Taylor series so no real arithmetic reaches hardware.
  function automatic int quarter_sine(input int k, input int depth, input int amp);
    longint x;
    longint x2;
    longint term;
    longint sum;
    x    = (PI_Q30 * longint'(2 * k + 1)) / longint'(4 * depth);
    x2   = (x * x) / Q30_ONE;
    term = x;
    sum  = x;
    for (int n = 1; n < 8; n++) begin
      term = -((term * x2) / Q30_ONE) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + Q30_ONE / 2) / Q30_ONE);
  endfunction

endpackage

// File: rtl/sine_tick_div.sv
module sine_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: an enable never lasts two clocks in a row
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sine_phase_acc.sv
module sine_phase_acc #(
  parameter int TUNE_W = 16,
  parameter int ACC_W  = 21,
  parameter int TOP_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TUNE_W-1:0] tune,
  output logic [TOP_W-1:0]  phase_top
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick) phase_d = phase_q + ACC_W'(tune);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_top = phase_q[ACC_W-1 -: TOP_W];

  // R8: the phase moves only on enabled clocks
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));

  // R7: a zero tuning word leaves the phase unchanged
  assert_zero_tune_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tune == '0) |=> $stable(phase_q));

endmodule

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut #(
  parameter int ADDR_W = 7,
  parameter int MAG_W  = 7
) (
  input  logic [ADDR_W+1:0] phase_top,
  output logic [MAG_W:0]    code
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int AMP   = 2 ** MAG_W - 1;

  logic [MAG_W-1:0]  rom [DEPTH];
  logic              sign_bit;
  logic              quad_bit;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] idx;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = MAG_W'(sine_dds_pkg::quarter_sine(k, DEPTH, AMP));
  end

  always_comb begin
    sign_bit = phase_top[ADDR_W+1];
    quad_bit = phase_top[ADDR_W];
    addr     = phase_top[ADDR_W-1:0];
    idx      = quad_bit ? ~addr : addr;
    code     = {sign_bit, rom[idx]};
  end

endmodule

// File: rtl/sine_dds_core.sv
module sine_dds_core #(
  parameter int TUNE_W = 16,
  parameter int ACC_W  = 21,
  parameter int ADDR_W = 7,
  parameter int MAG_W  = 7,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TUNE_W-1:0] tune_word,
  output logic [MAG_W:0]    sample_code,
  output logic              sample_valid
);
  localparam int TOP_W = ADDR_W + 2;

  logic             tick;
  logic [TOP_W-1:0] phase_top;
  logic [MAG_W:0]   lut_code;
  logic [MAG_W:0]   code_q;
  logic [MAG_W:0]   code_d;
  logic             valid_q;
  logic             valid_d;

  sine_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  sine_phase_acc #(.TUNE_W(TUNE_W), .ACC_W(ACC_W), .TOP_W(TOP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .tune     (tune_word),
    .phase_top(phase_top)
  );

  sine_quarter_lut #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_lut (
    .phase_top(phase_top),
    .code     (lut_code)
  );

  always_comb begin
    code_d  = tick ? lut_code : code_q;
    valid_d = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= valid_d;
    end
  end

  assign sample_code  = code_q;
  assign sample_valid = valid_q;

  // R2: strobe follows every enable and lasts one clock
  assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sample_valid);
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R8: the held sample changes only when an enable was present
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sample_code));

  // R6: every table magnitude is at least one
  assert_mag_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample_code[MAG_W-1:0] != '0));

endmodule

// File: tb/sine_dds_core_test.sv
module sine_dds_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  localparam int WATCHDOG   = 100000;
  localparam logic [15:0] VEC_TUNE [NVEC] = '{16'h1000, 16'hFFFF, 16'h0400,
                                              16'h8001, 16'h0001, 16'h0000};
  localparam int VEC_UPD [NVEC] = '{264, 40, 40, 40, 40, 20};

  logic        clk;
  logic        rst_n;
  logic [15:0] tune_word;
  logic [7:0]  sample_code;
  logic        sample_valid;
  int          n_checks;
  int          n_fails;
  bit          done;

  sine_dds_core uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tune_word   (tune_word),
    .sample_code (sample_code),
    .sample_valid(sample_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ref_code(input logic [20:0] ph);
    logic [6:0] a;
    int         mag;
    a = ph[18:12];                       // R5: bits 11:0 discarded
    if (ph[19]) a = ~a;                  // R5: mirrored quadrant
    mag = $rtoi(127.0 * $sin(3.14159265358979 * real'(2 * int'(a) + 1) / 512.0) + 0.5); // R6
    return {24'd0, ph[20], mag[6:0]};    // R4: sign on bit 7
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [15:0] tw);
    @(negedge clk);
    rst_n     = 1'b0;
    tune_word = tw;
    @(negedge clk);
    check("R1 code in reset", int'(sample_code), 0);
    check("R1 valid in reset", int'(sample_valid), 0);
    rst_n = 1'b1;
  endtask

  // R3: the bench keeps its own 21-bit phase and advances it by D per update
  task automatic run_vector(input logic [15:0] tw, input int nupd);
    logic [20:0] ph;
    int          prev;
    int          exp;
    string       tag;
    do_reset(tw);
    ph   = '0;
    prev = 0;
    for (int c = 1; c <= nupd * 4; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c % 4 == 0) begin
        check("R2 strobe on update", int'(sample_valid), 1);
        exp = ref_code(ph);
        if (tw == 16'h0) tag = "R7 frozen sample";
        else if (sample_code[7] != exp[7]) tag = "R4 sign bit";
        else if (ph[19]) tag = "R5 folded quadrant";
        else if (ph[18:12] == 7'd0 || ph[18:12] == 7'd127) tag = "R6 table end";
        else tag = "R3 accumulated phase";
        check(tag, int'(sample_code), exp);
        ph   = ph + 21'(tw);
        prev = int'(sample_code);
      end else begin
        check("R2 strobe idle", int'(sample_valid), 0);
        check("R8 code held", int'(sample_code), prev);
      end
    end
  endtask

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    tune_word = '0;
    #1;
    check("R1 code at start", int'(sample_code), 0);
    check("R1 valid at start", int'(sample_valid), 0);
    for (int v = 0; v < NVEC; v++) run_vector(VEC_TUNE[v], VEC_UPD[v]);

    // R1: reset asserted mid-run clears the outputs at once
    run_vector(16'h5555, 12);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 code after mid-run reset", int'(sample_code), 0);
    check("R1 valid after mid-run reset", int'(sample_valid), 0);
    rst_n = 1'b1;

    // R6: direct table ends, index 127 then mirrored index 127 at the quadrant boundary
    do_reset(16'h1000);
    repeat (128 * 4) @(posedge clk);
    @(negedge clk);
    check("R6 index 127 value", int'(sample_code), 8'h7F);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 mirror at quadrant start", int'(sample_code), 8'h7F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule